// File: doc/BRIEF.md
# Prioritized Ternary Packet Classifier

This block accepts one 104-bit five-tuple header per cycle and returns a permit or reject verdict for it. The verdict comes from an ordered table of rules. Each rule stores a pattern, a mask that marks some pattern bits as don't-care, and an action. Every valid rule compares against the header in parallel. A carried "earlier rule already hit" chain then gives the verdict to the lowest-numbered rule that matches. When no rule matches, a programmable fallback action applies.

Software-side logic fills the table through a single write port. Each write carries a slot index, a pattern, a mask, an action and a valid bit. A separate strobe sets the fallback action. The verdict, a hit flag and the index of the winning slot are registered and appear one cycle after the header strobe. Only the header is examined, and payload bytes never reach the block.

Top module: `pkt_filter_top`

## Requirements
- R1: Header bit positions are protocol [103:96], destination port [95:80], source port [79:64], destination address [63:32] and source address [31:0]. Rule patterns and masks use the same positions, so a rule can select any one field by caring only about that field's bits.
- R2: A mask bit of 1 marks that pattern bit as don't-care. A valid rule matches when every bit with mask 0 equals the corresponding header bit.
- R3: Of all valid rules that match, the one with the lowest slot index (slot 0 is highest priority) sets `decPermit` and `decIdx`, and `decHit` is 1.
- R4: A slot written with `ruleWrValid`=0 never matches, whatever its pattern and mask.
- R5: When no valid rule matches, `decHit` is 0, `decIdx` is 0 and `decPermit` equals the fallback action.
- R6: The fallback action resets to reject. A cycle with `defWrEn`=1 loads it from `defPermit`. On `decPermit`, 1 means permit and 0 means reject.
- R7: `decValid` is 1 in exactly the cycle after a cycle with `hdrValid`=1. While `decValid` is 0, `decPermit`, `decHit` and `decIdx` hold their last values.
- R8: A rule write or a fallback write in the same cycle as a lookup does not affect that lookup. It takes effect from the next lookup onward.
- R9: After reset, every slot is invalid, and `decValid`, `decPermit`, `decHit` and `decIdx` are all 0.
- R10: Writing a slot that already holds a rule fully replaces its pattern, mask, action and valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hdrValid | input | 1 | A header is presented for lookup this cycle |
| hdrData | input | 104 | Five-tuple header |
| ruleWrEn | input | 1 | Write one rule slot this cycle |
| ruleWrIdx | input | 4 | Slot to write |
| ruleWrValue | input | 104 | Pattern bits |
| ruleWrMask | input | 104 | Don't-care mask (1 = ignore bit) |
| ruleWrPermit | input | 1 | Rule action, 1 = permit |
| ruleWrValid | input | 1 | Slot is active |
| defWrEn | input | 1 | Load the fallback action |
| defPermit | input | 1 | Fallback action value, 1 = permit |
| decValid | output | 1 | A verdict is presented this cycle |
| decPermit | output | 1 | Verdict, 1 = permit, 0 = reject |
| decHit | output | 1 | A rule matched |
| decIdx | output | 4 | Slot that decided, 0 on a miss |

## Verification
Lookups use headers that match no rule, exactly one rule, and two overlapping rules. This separates the fallback path, the ternary compare and the priority chain. Some rules care only about one field (a /8 source prefix, an exact destination port, a protocol with one don't-care bit), so a swapped field position or an inverted mask shows up as a wrong hit. Writes placed in the same cycle as a lookup, invalidating writes, and overwrites of an occupied slot each tell apart when and how table state reaches the compare. Idle gaps and back-to-back strobes check that the verdict is registered once and held.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int HDR_W     = 104;
  localparam int NUM_RULES = 16;

  // strobes issued by control to the datapath
  typedef struct packed {
    logic lookup;
    logic ruleWr;
  } pfStrobe_t;
endpackage

// File: rtl/pf_ctrl.sv
module pf_ctrl (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hdrValid,
  input  logic             ruleWrEn,
  input  logic             defWrEn,
  input  logic             defPermitIn,
  output pf_pkg::pfStrobe_t strobe,
  output logic             defAction,
  output logic             decValid
);
  always_comb begin
    strobe.lookup = hdrValid;
    strobe.ruleWr = ruleWrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      defAction <= 1'b0;
      decValid  <= 1'b0;
    end else begin
      decValid <= hdrValid;
      if (defWrEn) defAction <= defPermitIn;
    end
  end
endmodule

// File: rtl/pf_rule_slot.sv
module pf_rule_slot #(
  parameter int HDR_W = 104
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [HDR_W-1:0] wrValue,
  input  logic [HDR_W-1:0] wrMask,
  input  logic             wrPermit,
  input  logic             wrValid,
  input  logic [HDR_W-1:0] hdr,
  output logic             match,
  output logic             permit
);
  logic [HDR_W-1:0] value;
  logic [HDR_W-1:0] mask;
  logic             active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      value  <= '0;
      mask   <= '0;
      permit <= 1'b0;
      active <= 1'b0;
    end else if (wrEn) begin
      value  <= wrValue;
      mask   <= wrMask;
      permit <= wrPermit;
      active <= wrValid;
    end
  end

  // cared bits (mask 0) must agree
  always_comb match = active && (((hdr ^ value) & ~mask) == '0);
endmodule

// File: rtl/pf_prio_chain.sv
module pf_prio_chain #(
  parameter int NUM_RULES = 16,
  localparam int IDX_W = $clog2(NUM_RULES)
) (
  input  logic [NUM_RULES-1:0] matchVec,
  input  logic [NUM_RULES-1:0] permitVec,
  output logic                 anyHit,
  output logic [IDX_W-1:0]     hitIdx,
  output logic                 hitPermit
);
  logic [NUM_RULES:0]   prevMatch;
  logic [NUM_RULES-1:0] take;

  assign prevMatch[0] = 1'b0;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_stage
    assign take[g]        = matchVec[g] & ~prevMatch[g];
    assign prevMatch[g+1] = prevMatch[g] | matchVec[g];
  end

  assign anyHit    = prevMatch[NUM_RULES];
  assign hitPermit = |(take & permitVec);

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < NUM_RULES; i++)
      if (take[i]) hitIdx = hitIdx | IDX_W'(i);
  end
endmodule

// File: rtl/pf_datapath.sv
module pf_datapath #(
  parameter int HDR_W     = 104,
  parameter int NUM_RULES = 16,
  localparam int IDX_W = $clog2(NUM_RULES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pf_pkg::pfStrobe_t strobe,
  input  logic              defAction,
  input  logic [HDR_W-1:0]  hdrData,
  input  logic [IDX_W-1:0]  ruleWrIdx,
  input  logic [HDR_W-1:0]  ruleWrValue,
  input  logic [HDR_W-1:0]  ruleWrMask,
  input  logic              ruleWrPermit,
  input  logic              ruleWrValid,
  output logic              decPermit,
  output logic              decHit,
  output logic [IDX_W-1:0]  decIdx
);
  logic [NUM_RULES-1:0] matchVec;
  logic [NUM_RULES-1:0] permitVec;
  logic                 anyHit;
  logic [IDX_W-1:0]     hitIdx;
  logic                 hitPermit;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_slot
    logic slotWr;
    assign slotWr = strobe.ruleWr && (ruleWrIdx == IDX_W'(g));
    pf_rule_slot #(.HDR_W(HDR_W)) i_slot (
      .clk      (clk),
      .rstN     (rstN),
      .wrEn     (slotWr),
      .wrValue  (ruleWrValue),
      .wrMask   (ruleWrMask),
      .wrPermit (ruleWrPermit),
      .wrValid  (ruleWrValid),
      .hdr      (hdrData),
      .match    (matchVec[g]),
      .permit   (permitVec[g])
    );
  end

  pf_prio_chain #(.NUM_RULES(NUM_RULES)) i_chain (
    .matchVec  (matchVec),
    .permitVec (permitVec),
    .anyHit    (anyHit),
    .hitIdx    (hitIdx),
    .hitPermit (hitPermit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decPermit <= 1'b0;
      decHit    <= 1'b0;
      decIdx    <= '0;
    end else if (strobe.lookup) begin
      decPermit <= anyHit ? hitPermit : defAction;
      decHit    <= anyHit;
      decIdx    <= anyHit ? hitIdx : '0;
    end
  end
endmodule

// File: rtl/pkt_filter_top.sv
module pkt_filter_top #(
  parameter int HDR_W     = pf_pkg::HDR_W,
  parameter int NUM_RULES = pf_pkg::NUM_RULES,
  localparam int IDX_W = $clog2(NUM_RULES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hdrValid,
  input  logic [HDR_W-1:0] hdrData,
  input  logic             ruleWrEn,
  input  logic [IDX_W-1:0] ruleWrIdx,
  input  logic [HDR_W-1:0] ruleWrValue,
  input  logic [HDR_W-1:0] ruleWrMask,
  input  logic             ruleWrPermit,
  input  logic             ruleWrValid,
  input  logic             defWrEn,
  input  logic             defPermit,
  output logic             decValid,
  output logic             decPermit,
  output logic             decHit,
  output logic [IDX_W-1:0] decIdx
);
  pf_pkg::pfStrobe_t strobe;
  logic              defAction;

  pf_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hdrValid    (hdrValid),
    .ruleWrEn    (ruleWrEn),
    .defWrEn     (defWrEn),
    .defPermitIn (defPermit),
    .strobe      (strobe),
    .defAction   (defAction),
    .decValid    (decValid)
  );

  pf_datapath #(.HDR_W(HDR_W), .NUM_RULES(NUM_RULES)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .defAction    (defAction),
    .hdrData      (hdrData),
    .ruleWrIdx    (ruleWrIdx),
    .ruleWrValue  (ruleWrValue),
    .ruleWrMask   (ruleWrMask),
    .ruleWrPermit (ruleWrPermit),
    .ruleWrValid  (ruleWrValid),
    .decPermit    (decPermit),
    .decHit       (decHit),
    .decIdx       (decIdx)
  );
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             hdrValid,
  input logic             defWrEn,
  input logic             defPermit,
  input logic             decValid,
  input logic             decPermit,
  input logic             decHit,
  input logic [IDX_W-1:0] decIdx
);
  // checker's own copy of the fallback action, written like the spec says
  logic defShadow;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) defShadow <= 1'b0;
    else if (defWrEn) defShadow <= defPermit;
  end

  // R7
  verdict_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> decValid);

  // R7
  no_spurious_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> !decValid);

  // R7
  verdict_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> ($stable(decPermit) && $stable(decHit) && $stable(decIdx)));

  // R5
  miss_index_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decHit) |-> (decIdx == '0));

  // R5 R6 R8: a miss uses the fallback value held during the lookup cycle
  miss_uses_fallback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decHit) |-> (decPermit == $past(defShadow)));
endmodule

bind pkt_filter_top pf_checker #(.IDX_W(IDX_W)) i_pf_checker (
  .clk       (clk),
  .rstN      (rstN),
  .hdrValid  (hdrValid),
  .defWrEn   (defWrEn),
  .defPermit (defPermit),
  .decValid  (decValid),
  .decPermit (decPermit),
  .decHit    (decHit),
  .decIdx    (decIdx)
);

// File: tb/test_pkt_filter_top.sv
module test_pkt_filter_top;
  localparam int HW = 104;
  localparam int NR = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdrValid = 1'b0;
  logic [HW-1:0] hdrData = '0;
  logic ruleWrEn = 1'b0;
  logic [IW-1:0] ruleWrIdx = '0;
  logic [HW-1:0] ruleWrValue = '0;
  logic [HW-1:0] ruleWrMask = '0;
  logic ruleWrPermit = 1'b0;
  logic ruleWrValid = 1'b0;
  logic defWrEn = 1'b0;
  logic defPermit = 1'b0;
  logic decValid, decPermit, decHit;
  logic [IW-1:0] decIdx;

  always #2 clk = ~clk;

  pkt_filter_top i_pkt_filter_top (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrData(hdrData),
    .ruleWrEn(ruleWrEn), .ruleWrIdx(ruleWrIdx), .ruleWrValue(ruleWrValue),
    .ruleWrMask(ruleWrMask), .ruleWrPermit(ruleWrPermit), .ruleWrValid(ruleWrValid),
    .defWrEn(defWrEn), .defPermit(defPermit),
    .decValid(decValid), .decPermit(decPermit), .decHit(decHit), .decIdx(decIdx)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench reference table
  logic [HW-1:0] mVal [NR];
  logic [HW-1:0] mMask[NR];
  logic          mAct [NR];
  logic          mVld [NR];
  logic          mDef = 1'b0;

  logic [IW+1:0] expQ[$];   // {permit, hit, idx}
  string         tagQ[$];

  logic lastPermit, lastHit;
  logic [IW-1:0] lastIdx;

  function automatic logic [HW-1:0] mkHdr(logic [31:0] sip, logic [31:0] dip,
      logic [15:0] sp, logic [15:0] dp, logic [7:0] proto);
    return {proto, dp, sp, dip, sip};
  endfunction

  function automatic logic [IW+1:0] predict(logic [HW-1:0] h);
    for (int i = 0; i < NR; i++) begin
      if (mVld[i] && (((h ^ mVal[i]) & ~mMask[i]) == '0))
        return {mAct[i], 1'b1, IW'(i)};
    end
    return {mDef, 1'b0, IW'(0)};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected verdict pushed before model writes
  task automatic drive(bit look, logic [HW-1:0] h, string tag,
      bit wr, int wIdx, logic [HW-1:0] wVal, logic [HW-1:0] wMask, bit wAct, bit wVld,
      bit dw, bit dp);
    @(posedge clk); #1;
    hdrValid = look; hdrData = h;
    ruleWrEn = wr; ruleWrIdx = IW'(wIdx); ruleWrValue = wVal; ruleWrMask = wMask;
    ruleWrPermit = wAct; ruleWrValid = wVld;
    defWrEn = dw; defPermit = dp;
    if (look) begin
      expQ.push_back(predict(h));
      tagQ.push_back(tag);
    end
    if (wr) begin
      mVal[wIdx] = wVal; mMask[wIdx] = wMask; mAct[wIdx] = wAct; mVld[wIdx] = wVld;
    end
    if (dw) mDef = dp;
  endtask

  task automatic idle();
    drive(0, '0, "", 0, 0, '0, '0, 0, 0, 0, 0);
  endtask

  task automatic lookup(logic [HW-1:0] h, string tag);
    drive(1, h, tag, 0, 0, '0, '0, 0, 0, 0, 0);
  endtask

  task automatic setRule(int idx, logic [HW-1:0] v, logic [HW-1:0] m, bit act, bit vld);
    drive(0, '0, "", 1, idx, v, m, act, vld, 0, 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && decValid) begin
      if (expQ.size() == 0) begin
        check(0, "R7", "unexpected verdict", 1, 0);
      end else begin
        logic [IW+1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({decPermit, decHit, decIdx} === e, t, "verdict {permit,hit,idx}",
              int'({decPermit, decHit, decIdx}), int'(e));
      end
      lastPermit <= decPermit; lastHit <= decHit; lastIdx <= decIdx;
    end
  end

  // full-care masks for single fields (mask 1 = don't care)
  localparam logic [HW-1:0] ALL_DC   = {HW{1'b1}};
  localparam logic [HW-1:0] CARE_SIP8 = ~(HW'(32'hFF00_0000));
  localparam logic [HW-1:0] CARE_DP   = ~(HW'(16'hFFFF) << 80);
  localparam logic [HW-1:0] CARE_PR   = ~(HW'(8'hFE) << 96);

  initial begin
    for (int i = 0; i < NR; i++) begin
      mVal[i] = '0; mMask[i] = '0; mAct[i] = 0; mVld[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    check({decValid, decPermit, decHit, decIdx} == '0, "R9", "reset outputs",
          int'({decValid, decPermit, decHit, decIdx}), 0);
    rstN = 1'b1;
    idle();

    // empty table: fallback reject
    lookup(mkHdr(32'h0A01_0203, 32'hC0A8_0001, 16'd1234, 16'd80, 8'd6), "R5 R6 R9");
    // fallback permit
    drive(0, '0, "", 0, 0, '0, '0, 0, 0, 1, 1);
    lookup(mkHdr(32'h0A01_0203, 32'hC0A8_0001, 16'd1234, 16'd80, 8'd6), "R6");
    drive(0, '0, "", 0, 0, '0, '0, 0, 0, 1, 0);

    // slot 5: exact dst port 80 permit; slot 2: src 10/8 reject
    setRule(5, HW'(16'd80) << 80, CARE_DP, 1, 1);
    setRule(2, HW'(32'h0A00_0000), CARE_SIP8, 0, 1);
    // slot 9: protocol 6 or 7 (bit 96 don't care) permit
    setRule(9, HW'(8'd6) << 96, CARE_PR, 1, 1);
    idle();

    lookup(mkHdr(32'hC0A8_0101, 32'h0808_0808, 16'd5000, 16'd80, 8'd17), "R1 R2 dport only");
    lookup(mkHdr(32'h0A05_0607, 32'h0808_0808, 16'd5000, 16'd80, 8'd17), "R3 overlap");
    lookup(mkHdr(32'hC0A8_0101, 32'h0808_0808, 16'd80, 16'd81, 8'd17), "R1 R2 sport not dport");
    lookup(mkHdr(32'hC0A8_0101, 32'h0808_0808, 16'd1, 16'd2, 8'd7), "R2 proto dont-care bit");
    lookup(mkHdr(32'hC0A8_0101, 32'h0808_0808, 16'd1, 16'd2, 8'd4), "R2 proto miss");
    lookup(mkHdr(32'h0B05_0607, 32'h0A00_0000, 16'd1, 16'd2, 8'd1), "R1 dst not src");

    // idle gap: outputs hold
    idle(); idle();
    @(negedge clk);
    check(!decValid, "R7", "decValid during idle", int'(decValid), 0);
    check({decPermit, decHit, decIdx} == {lastPermit, lastHit, lastIdx}, "R7", "held verdict",
          int'({decPermit, decHit, decIdx}), int'({lastPermit, lastHit, lastIdx}));

    // invalidate slot 2
    setRule(2, HW'(32'h0A00_0000), CARE_SIP8, 0, 0);
    lookup(mkHdr(32'h0A05_0607, 32'h0808_0808, 16'd5000, 16'd80, 8'd17), "R4 invalid slot");

    // same-cycle write of slot 0 (match all, reject) and fallback permit
    drive(1, mkHdr(32'hC0A8_0101, 32'h0808_0808, 16'd5000, 16'd80, 8'd17), "R8 old rules",
          1, 0, '0, ALL_DC, 0, 1, 1, 1);
    lookup(mkHdr(32'hC0A8_0101, 32'h0808_0808, 16'd5000, 16'd80, 8'd17), "R8 new rule");
    // disable slot 0 in lookup cycle, miss then uses the permit fallback
    drive(1, mkHdr(32'h1, 32'h2, 16'd3, 16'd4, 8'd5), "R8 slot0 still live",
          1, 0, '0, ALL_DC, 0, 0, 0, 0);
    lookup(mkHdr(32'h1, 32'h2, 16'd3, 16'd4, 8'd5), "R5 R8 fallback permit");

    // overwrite slot 5 with exact whole-header permit
    setRule(5, mkHdr(32'h1, 32'h2, 16'd3, 16'd4, 8'd5), '0, 1, 1);
    lookup(mkHdr(32'h1, 32'h2, 16'd3, 16'd4, 8'd5), "R10 overwrite hit");
    lookup(mkHdr(32'hC0A8_0101, 32'h0808_0808, 16'd5000, 16'd80, 8'd17), "R10 old pattern gone");

    idle(); idle(); idle();
    check(expQ.size() == 0, "R7", "verdicts outstanding", expQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule